// File: doc/BRIEF.md
# Wavetable Phase Incrementer with Unison

This block produces the read addresses that a wavetable oscillator needs for four polyphony voices. Each voice keeps three 32-bit phase accumulators. The first is a main phase at the pitch of the voice's note number. The other two are unison phases, detuned above and below that pitch by a programmable fraction. All accumulators advance once per sample tick. The table address for each phase is its top 8 bits, which indexes a 256-entry wavetable.

The increments do not depend on the clock frequency. Two parameters, the system clock frequency and the tick divider, give the sample rate FS = CLK_HZ / TICK_DIV, using integer division. The per-note increment is computed from FS when the design elaborates, so one RTL plays the correct pitch at any clock rate. Only the highest octave is held as constants. Lower notes are reached by right-shifting those values.

A voice that is inactive sits at phase zero. A voice that changes note, or that has just become active, restarts all three of its phases from zero. The addresses from every tick are qualified by a one-cycle valid strobe. The sample fetcher downstream reads them on that strobe.

Top module: `phinc_top`

## Requirements
- R1: While reset is asserted (rst_n low) and at the first clock edge after it is released, `out_valid` is 0 and every address output is 0.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `tick` was 1, and is 0 otherwise, including when ticks come back to back.
- R3: Phases, and therefore all address outputs, change only at a clock edge where `tick` is 1.
- R4: At a tick where a voice's `voice_active` bit is 0, all three phases of that voice become 0.
- R5: At a tick where a voice is active, its three phases become 0 if either of two conditions holds: it was inactive at its previous tick, or its note differs from the note seen at its previous tick. Otherwise each phase adds its increment modulo 2^32.
- R6: The main increment of note n (7 bits, n = 12*k + s) is floor(T[s] / 2^(10-k)), where T[s] = floor(F[s] * 2^32 / (1000*FS)). F in millihertz for s = 0..11 is 8372018, 8869844, 9397273, 9956063, 10548082, 11175303, 11839822, 12543854, 13289750, 14080000, 14917240, 15804264.
- R7: Each address is bits 31:24 of its phase, and a phase that passes 2^32 wraps around.
- R8: With `detune` = d, an unsigned fraction d/65536, the upper unison increment is floor(B*(65536+d)/65536), where B is the main increment from R6.
- R9: The lower unison increment is floor(B*(65536-d)/65536).
- R10: Voices are independent: a voice's outputs depend only on its own `voice_active` bit, its own note field, the shared `detune` and `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample-rate strobe; phases advance when high |
| voice_active | input | 4 | Bit v is high while voice v is sounding |
| voice_note | input | 28 | Note number of voice v in bits [7v+6:7v] |
| detune | input | 16 | Unison detune fraction, unsigned, scaled by 1/65536 |
| addr_main | output | 32 | Main-phase table address of voice v in bits [8v+7:8v] |
| addr_up | output | 32 | Upper unison table address of voice v in bits [8v+7:8v] |
| addr_dn | output | 32 | Lower unison table address of voice v in bits [8v+7:8v] |
| out_valid | output | 1 | High for one cycle after each tick |

## Verification
Four properties are checked on every cycle: the valid strobe lags the tick by one cycle, the addresses hold still between ticks, an inactive voice is forced to zero, and a voice restarts after a note change. These rules are local in time. The arithmetic cannot be checked that way. The per-note increments, the octave shifting, the truncation of the unison multiplies and the wrap of a phase show up only when the bench's reference model accumulates the same sequence of ticks and compares every address. That model is driven through scripted note changes, extreme detune values and random traffic.

// File: rtl/phinc_pkg.sv
package phinc_pkg;

    // Highest-octave note frequencies in millihertz, indexed by semitone.
    function automatic longint unsigned top_freq_mhz(input int semi);
        case (semi)
            0:       return 64'd8372018;
            1:       return 64'd8869844;
            2:       return 64'd9397273;
            3:       return 64'd9956063;
            4:       return 64'd10548082;
            5:       return 64'd11175303;
            6:       return 64'd11839822;
            7:       return 64'd12543854;
            8:       return 64'd13289750;
            9:       return 64'd14080000;
            10:      return 64'd14917240;
            11:      return 64'd15804264;
            default: return 64'd0;
        endcase
    endfunction

    // Phase step per sample for a top-octave semitone, scaled to 2^pw.
    function automatic longint unsigned semi_step(input int semi, input int pw,
                                                  input longint unsigned fs_hz);
        longint unsigned num;
        num = top_freq_mhz(semi) << pw;
        return num / (fs_hz * 64'd1000);
    endfunction

endpackage

// File: rtl/phinc_note_rom.sv
module phinc_note_rom
    import phinc_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int TICK_DIV = 1024,
    parameter int PW       = 32,
    parameter int NW       = 7
) (
    input  logic [NW-1:0] note,
    output logic [PW-1:0] step
);
    localparam longint unsigned FS = longint'(CLK_HZ / TICK_DIV);
    localparam int TOP_OCT = ((1 << NW) - 1) / 12;
    localparam int OW      = $clog2(TOP_OCT + 1);

    logic [PW-1:0] oct_tab [16];

    genvar s;
    generate
        for (s = 0; s < 16; s++) begin : g_tab
            if (s < 12) begin : g_used
                localparam longint unsigned V = semi_step(s, PW, FS);
                assign oct_tab[s] = PW'(V);
            end else begin : g_pad
                assign oct_tab[s] = '0;
            end
        end
    endgenerate

    logic [3:0]    semi;
    logic [OW-1:0] octave;
    logic [OW-1:0] shamt;

    always_comb begin
        semi   = 4'(note % NW'(12));
        octave = OW'(note / NW'(12));
        shamt  = OW'(TOP_OCT) - octave;
        step   = oct_tab[semi] >> shamt;
    end

endmodule

// File: rtl/phinc_unison.sv
module phinc_unison #(
    parameter int PW = 32,
    parameter int DW = 16
) (
    input  logic [PW-1:0] base,
    input  logic [DW-1:0] detune,
    output logic [PW-1:0] step_up,
    output logic [PW-1:0] step_dn
);
    localparam int MW = PW + DW + 1;
    localparam logic [DW:0] UNITY = {1'b1, {DW{1'b0}}};

    logic [DW:0]   fac_up;
    logic [DW:0]   fac_dn;
    logic [MW-1:0] prod_up;
    logic [MW-1:0] prod_dn;

    always_comb begin
        fac_up  = UNITY + {1'b0, detune};
        fac_dn  = UNITY - {1'b0, detune};
        prod_up = {{(DW+1){1'b0}}, base} * {{PW{1'b0}}, fac_up};
        prod_dn = {{(DW+1){1'b0}}, base} * {{PW{1'b0}}, fac_dn};
        step_up = PW'(prod_up >> DW);
        step_dn = PW'(prod_dn >> DW);
    end

endmodule

// File: rtl/phinc_voice.sv
module phinc_voice #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int TICK_DIV = 1024,
    parameter int PW       = 32,
    parameter int NW       = 7,
    parameter int DW       = 16,
    parameter int AW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          active,
    input  logic [NW-1:0] note,
    input  logic [DW-1:0] detune,
    output logic [AW-1:0] addr_main,
    output logic [AW-1:0] addr_up,
    output logic [AW-1:0] addr_dn
);
    typedef struct packed {
        logic [PW-1:0] ph_main;
        logic [PW-1:0] ph_up;
        logic [PW-1:0] ph_dn;
        logic [NW-1:0] last_note;
        logic          was_act;
    } voice_st_t;

    voice_st_t st_d, st_q;

    logic [PW-1:0] step_main;
    logic [PW-1:0] step_up;
    logic [PW-1:0] step_dn;
    logic          restart;

    phinc_note_rom #(
        .CLK_HZ  (CLK_HZ),
        .TICK_DIV(TICK_DIV),
        .PW      (PW),
        .NW      (NW)
    ) u_rom (
        .note(note),
        .step(step_main)
    );

    phinc_unison #(
        .PW(PW),
        .DW(DW)
    ) u_uni (
        .base   (step_main),
        .detune (detune),
        .step_up(step_up),
        .step_dn(step_dn)
    );

    always_comb begin
        st_d    = st_q;
        restart = !active || !st_q.was_act || (note != st_q.last_note);
        if (tick) begin
            if (restart) begin
                st_d.ph_main = '0;
                st_d.ph_up   = '0;
                st_d.ph_dn   = '0;
            end else begin
                st_d.ph_main = st_q.ph_main + step_main;
                st_d.ph_up   = st_q.ph_up + step_up;
                st_d.ph_dn   = st_q.ph_dn + step_dn;
            end
            st_d.last_note = note;
            st_d.was_act   = active;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_main = AW'(st_q.ph_main >> (PW - AW));
    assign addr_up   = AW'(st_q.ph_up >> (PW - AW));
    assign addr_dn   = AW'(st_q.ph_dn >> (PW - AW));

endmodule

// File: rtl/phinc_top.sv
module phinc_top #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int TICK_DIV    = 1024,
    parameter int NVOICE      = 4,
    parameter int PW          = 32,
    parameter int NW          = 7,
    parameter int DW          = 16,
    parameter int TABLE_DEPTH = 256,
    localparam int AW         = $clog2(TABLE_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NVOICE-1:0]    voice_active,
    input  logic [NVOICE*NW-1:0] voice_note,
    input  logic [DW-1:0]        detune,
    output logic [NVOICE*AW-1:0] addr_main,
    output logic [NVOICE*AW-1:0] addr_up,
    output logic [NVOICE*AW-1:0] addr_dn,
    output logic                 out_valid
);
    typedef struct packed {
        logic valid;
    } top_st_t;

    top_st_t top_d, top_q;

    genvar v;
    generate
        for (v = 0; v < NVOICE; v++) begin : g_voice
            phinc_voice #(
                .CLK_HZ  (CLK_HZ),
                .TICK_DIV(TICK_DIV),
                .PW      (PW),
                .NW      (NW),
                .DW      (DW),
                .AW      (AW)
            ) u_voice (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .active   (voice_active[v]),
                .note     (voice_note[v*NW +: NW]),
                .detune   (detune),
                .addr_main(addr_main[v*AW +: AW]),
                .addr_up  (addr_up[v*AW +: AW]),
                .addr_dn  (addr_dn[v*AW +: AW])
            );
        end
    endgenerate

    always_comb begin
        top_d       = top_q;
        top_d.valid = tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign out_valid = top_q.valid;

endmodule

// File: rtl/phinc_checks.sv
module phinc_checks #(
    parameter int NVOICE = 4,
    parameter int NW     = 7,
    parameter int DW     = 16,
    parameter int AW     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic [NVOICE-1:0]    voice_active,
    input logic [NVOICE*NW-1:0] voice_note,
    input logic [DW-1:0]        detune,
    input logic [NVOICE*AW-1:0] addr_main,
    input logic [NVOICE*AW-1:0] addr_up,
    input logic [NVOICE*AW-1:0] addr_dn,
    input logic                 out_valid
);
    // Observer copy of the note and activity seen at each voice's last tick.
    logic [NVOICE*NW-1:0] seen_note;
    logic [NVOICE-1:0]    seen_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_note <= '0;
            seen_act  <= '0;
        end else if (tick) begin
            seen_note <= voice_note;
            seen_act  <= voice_active;
        end
    end

    assert_valid_follows_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> out_valid);

    assert_valid_only_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !out_valid);

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(addr_main) && $stable(addr_up) && $stable(addr_dn)));

    genvar v;
    generate
        for (v = 0; v < NVOICE; v++) begin : g_chk
            assert_inactive_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && !voice_active[v]) |=>
                    (addr_main[v*AW +: AW] == '0 && addr_up[v*AW +: AW] == '0 &&
                     addr_dn[v*AW +: AW] == '0));

            assert_note_change_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && voice_active[v] && seen_act[v] &&
                 voice_note[v*NW +: NW] != seen_note[v*NW +: NW]) |=>
                    (addr_main[v*AW +: AW] == '0 && addr_up[v*AW +: AW] == '0 &&
                     addr_dn[v*AW +: AW] == '0));
        end
    endgenerate

endmodule

bind phinc_top phinc_checks #(
    .NVOICE(NVOICE),
    .NW    (NW),
    .DW    (DW),
    .AW    (AW)
) u_phinc_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .voice_active(voice_active),
    .voice_note  (voice_note),
    .detune      (detune),
    .addr_main   (addr_main),
    .addr_up     (addr_up),
    .addr_dn     (addr_dn),
    .out_valid   (out_valid)
);

// File: tb/tb_phinc_top.sv
`timescale 1ns/1ps
module tb_phinc_top;
    localparam int CLK_HZ   = 50_000_000;
    localparam int TICK_DIV = 1024;
    localparam longint unsigned FS = longint'(CLK_HZ / TICK_DIV);
    localparam int WATCHDOG_NS = 4_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  voice_active = '0;
    logic [27:0] voice_note = '0;
    logic [15:0] detune = '0;
    logic [31:0] addr_main, addr_up, addr_dn;
    logic        out_valid;

    always #10 clk = ~clk;

    phinc_top #(.CLK_HZ(CLK_HZ), .TICK_DIV(TICK_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .voice_active(voice_active),
        .voice_note(voice_note), .detune(detune), .addr_main(addr_main),
        .addr_up(addr_up), .addr_dn(addr_dn), .out_valid(out_valid)
    );

    int nvec = 0;
    int nerr = 0;
    bit done = 0;
    string scen = "R1 reset";

    longint unsigned freq_mhz [12] = '{64'd8372018, 64'd8869844, 64'd9397273,
        64'd9956063, 64'd10548082, 64'd11175303, 64'd11839822, 64'd12543854,
        64'd13289750, 64'd14080000, 64'd14917240, 64'd15804264};

    // Reference model state
    bit [31:0] m_ph [4][3];
    bit [6:0]  m_last [4];
    bit        m_was [4];
    bit        m_valid;

    function automatic bit [31:0] ref_main(input bit [6:0] n);
        longint unsigned t;
        int k;
        t = (freq_mhz[n % 12] << 32) / (FS * 64'd1000);
        k = n / 12;
        return 32'(t >> (10 - k));
    endfunction

    function automatic bit [31:0] ref_up(input bit [31:0] b, input bit [15:0] d);
        return 32'((longint'(b) * (64'd65536 + longint'(d))) >> 16);
    endfunction

    function automatic bit [31:0] ref_dn(input bit [31:0] b, input bit [15:0] d);
        return 32'((longint'(b) * (64'd65536 - longint'(d))) >> 16);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0;
            for (int v = 0; v < 4; v++) begin
                for (int j = 0; j < 3; j++) m_ph[v][j] = '0;
                m_last[v] = '0;
                m_was[v]  = 0;
            end
        end else begin
            m_valid = tick;
            if (tick) begin
                for (int v = 0; v < 4; v++) begin
                    bit [6:0]  n;
                    bit [31:0] b;
                    n = voice_note[v*7 +: 7];
                    b = ref_main(n);
                    if (!voice_active[v] || !m_was[v] || n != m_last[v]) begin
                        for (int j = 0; j < 3; j++) m_ph[v][j] = '0;
                    end else begin
                        m_ph[v][0] = m_ph[v][0] + b;
                        m_ph[v][1] = m_ph[v][1] + ref_up(b, detune);
                        m_ph[v][2] = m_ph[v][2] + ref_dn(b, detune);
                    end
                    m_last[v] = n;
                    m_was[v]  = voice_active[v];
                end
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s [%s]: actual %0d expected %0d", tag, scen, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 out_valid", out_valid, m_valid);
        for (int v = 0; v < 4; v++) begin
            chk($sformatf("R6 R7 main v%0d", v), addr_main[v*8 +: 8], m_ph[v][0][31:24]);
            chk($sformatf("R8 upper v%0d", v),   addr_up[v*8 +: 8],   m_ph[v][1][31:24]);
            chk($sformatf("R9 lower v%0d", v),   addr_dn[v*8 +: 8],   m_ph[v][2][31:24]);
        end
    endtask

    // Sample at the falling edge, then drive the next inputs.
    task automatic step(input bit t);
        @(negedge clk);
        if (rst_n) compare_all();
        tick = t;
    endtask

    task automatic set_note(input int v, input int n);
        voice_note[v*7 +: 7] = 7'(n);
    endtask

    task automatic voice_zero(input int v, input string tag);
        chk({tag, " main zero"}, addr_main[v*8 +: 8], 0);
        chk({tag, " up zero"},   addr_up[v*8 +: 8],   0);
        chk({tag, " dn zero"},   addr_dn[v*8 +: 8],   0);
    endtask

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            nerr++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with tick driven during reset
        tick = 1'b1;
        voice_active = 4'hF;
        voice_note = {7'd100, 7'd90, 7'd80, 7'd70};
        repeat (3) begin
            @(negedge clk);
            chk("R1 valid in reset", out_valid, 0);
            chk("R1 main in reset", addr_main, 0);
            chk("R1 up in reset", addr_up, 0);
            chk("R1 dn in reset", addr_dn, 0);
        end
        tick = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", out_valid, 0);
        chk("R1 main after release", addr_main, 0);

        // Main function with a ~5% detune, one voice idle; v2 wraps fast (R7)
        scen = "R6 R8 R9 mixed notes";
        voice_active = 4'b0111;
        set_note(0, 69); set_note(1, 60); set_note(2, 127); set_note(3, 12);
        detune = 16'h0CCD;
        for (int i = 0; i < 60; i++) step(i[0]);

        // R3: no ticks, outputs must hold
        scen = "R3 no tick";
        step(0);
        for (int i = 0; i < 12; i++) step(0);

        // R5: note change on voice 0 restarts it; R10: voice 1 continues
        scen = "R5 R10 note change";
        set_note(0, 81);
        step(1);
        step(0);
        voice_zero(0, "R5 voice0 after note change");
        for (int i = 0; i < 20; i++) step(i[0]);

        // R4: deactivate voice 1
        scen = "R4 inactive";
        voice_active = 4'b0101;
        step(1);
        step(0);
        voice_zero(1, "R4 voice1 inactive");
        for (int i = 0; i < 10; i++) step(i[0]);

        // R8 R9 extremes of detune
        scen = "R8 R9 max detune";
        voice_active = 4'b1111;
        detune = 16'hFFFF;
        for (int i = 0; i < 30; i++) step(i[0]);
        scen = "R8 R9 zero detune";
        detune = 16'h0000;
        for (int i = 0; i < 30; i++) step(i[0]);

        // R2: back-to-back ticks
        scen = "R2 back to back";
        detune = 16'h2000;
        for (int i = 0; i < 30; i++) step(1);
        step(0);
        step(0);

        // R10 and general: random traffic
        scen = "R10 random";
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 16) == 0) voice_active = 4'($urandom);
            if (($urandom % 12) == 0) set_note($urandom % 4, $urandom % 128);
            if (($urandom % 40) == 0) detune = 16'($urandom);
            step(($urandom % 3) != 0);
        end
        step(0);
        step(0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule